// File: doc/BRIEF.md
# USB IN Endpoint Transfer Counter

This block keeps the transfer bookkeeping for one USB device IN endpoint. A 32-bit word holds three fields: the bytes still to be fetched from memory, the packets still to be sent, and a packets-per-microframe count. Software loads the word through a simple write port while the endpoint is idle, then raises a one-cycle enable request. From then on the block owns the word. A FIFO write event subtracts the packet length from the byte field. A FIFO read event takes one from the packet field.

When both fields have run down to zero, the block drops the endpoint enable on its own and gives a single-cycle transfer-complete pulse. A byte count that is set to one maximum packet therefore gives one pulse per packet. For isochronous endpoints the block also presents the data PID for the next packet, based on the packets-per-microframe value and on how many packets have already gone out in the current microframe.

Top module: `usb_in_xfer_ctr`

## Requirements
- R1: After reset the read word is all zeros, and `ep_enabled`, `xfer_done_irq` and `len_err` are low. `data_pid` is DATA0 (code 0).
- R2: The read word places the byte count in bits 18:0, the packet count in bits 28:19 and the multi-count in bits 30:29. Bit 31 always reads 0. A write while the endpoint is disabled shows on the read word from the next cycle.
- R3: A register write while the endpoint is enabled leaves every field unchanged.
- R4: While enabled, each `fifo_wr_evt` cycle lowers the byte count by `fifo_wr_len` at the next clock edge.
- R5: While enabled, each `fifo_rd_evt` cycle lowers the packet count by one at the next clock edge. FIFO events while disabled change nothing.
- R6: At the first clock edge where both counts are zero after the event updates, `ep_enabled` goes low. `xfer_done_irq` is high for exactly the following cycle. A packet count at zero while bytes remain does not complete the transfer.
- R7: A write event longer than the remaining byte count leaves the byte count at zero and sets `len_err`. The flag stays set until the next accepted register write clears it.
- R8: With `iso_ep` high, the first packet after `uframe_start` carries PID code mc-1, where mc is the multi-count field. Each packet read lowers the code by one, down to a floor of 0. Codes are 0=DATA0, 1=DATA1 and 2=DATA2. With `iso_ep` low, or with a multi-count of 0, the code is 0.
- R9: A write event and a read event in the same cycle both take effect at the same edge.
- R10: An `ep_en_set` pulse while disabled raises `ep_enabled` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write value |
| ep_en_set | input | 1 | Request to enable the endpoint |
| iso_ep | input | 1 | Endpoint is isochronous |
| uframe_start | input | 1 | Start of a microframe |
| fifo_wr_evt | input | 1 | A packet is written into the transmit FIFO |
| fifo_wr_len | input | 11 | Length in bytes of that packet |
| fifo_rd_evt | input | 1 | A packet is read out of the transmit FIFO |
| cfg_rd_data | output | 32 | Current register contents |
| ep_enabled | output | 1 | Endpoint enable state |
| xfer_done_irq | output | 1 | One-cycle transfer-complete pulse |
| len_err | output | 1 | Sticky byte-count overrun flag |
| data_pid | output | 2 | Isochronous data PID code |

## Verification
Two functions can land on the same clock edge. The byte subtraction from a FIFO write and the packet subtraction from a FIFO read can coincide, and when both bring their counts to zero, completion must be detected at that same edge. The bench drives both events in one cycle, first with counts left over and then with the final packet. It checks the intermediate read word and, in the final case, the enable drop and the single-cycle pulse.

// File: rtl/usb_in_xfer_pkg.sv
package usb_in_xfer_pkg;
  typedef enum logic [1:0] {
    PID_DATA0 = 2'd0,
    PID_DATA1 = 2'd1,
    PID_DATA2 = 2'd2
  } data_pid_e;
endpackage

// File: rtl/usb_in_byte_ctr.sv
module usb_in_byte_ctr #(
  parameter int W     = 19,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  input  logic             dec_en,
  input  logic [LEN_W-1:0] dec_len,
  output logic [W-1:0]     count,
  output logic [W-1:0]     count_nxt,
  output logic             overrun
);
  localparam int PAD = W + 1 - LEN_W;

  logic [W:0] len_wide;
  logic       upd;

  assign len_wide = {{PAD{1'b0}}, dec_len};
  assign upd      = load | dec_en;

  always_comb begin
    count_nxt = count;
    overrun   = 1'b0;
    if (load) begin
      count_nxt = load_val;
    end else if (dec_en) begin
      if (len_wide > {1'b0, count}) begin
        count_nxt = '0;
        overrun   = 1'b1;
      end else begin
        count_nxt = count - len_wide[W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (upd) begin
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/usb_in_pkt_ctr.sv
module usb_in_pkt_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] count,
  output logic [W-1:0] count_nxt
);
  logic upd;
  assign upd = load | dec_en;

  always_comb begin
    count_nxt = count;
    if (load) begin
      count_nxt = load_val;
    end else if (dec_en && (count != '0)) begin
      count_nxt = count - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (upd) begin
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/usb_in_iso_pid.sv
module usb_in_iso_pid
  import usb_in_xfer_pkg::*;
#(
  parameter int MC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iso,
  input  logic [MC_W-1:0] mc,
  input  logic            uframe_start,
  input  logic            pkt_sent,
  output data_pid_e       pid
);
  localparam logic [MC_W-1:0] SLOT_MAX = '1;

  logic [MC_W-1:0] slot;
  logic [MC_W-1:0] slot_nxt;
  logic [MC_W-1:0] mc_eff;
  logic [MC_W-1:0] first_code;
  logic [MC_W-1:0] code;
  logic            slot_upd;

  assign slot_upd = uframe_start | pkt_sent;

  always_comb begin
    slot_nxt = slot;
    if (uframe_start) begin
      slot_nxt = '0;
    end else if (pkt_sent && (slot != SLOT_MAX)) begin
      slot_nxt = slot + MC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (slot_upd) begin
      slot <= slot_nxt;
    end
  end

  always_comb begin
    mc_eff     = (mc == '0) ? MC_W'(1) : mc;
    first_code = mc_eff - MC_W'(1);
    if (!iso || (slot >= first_code)) begin
      code = '0;
    end else begin
      code = first_code - slot;
    end
    pid = data_pid_e'(code[1:0]);
  end
endmodule

// File: rtl/usb_in_xfer_ctr.sv
module usb_in_xfer_ctr
  import usb_in_xfer_pkg::*;
#(
  parameter int XFER_W = 19,
  parameter int PKT_W  = 10,
  parameter int MC_W   = 2,
  parameter int LEN_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [31:0]      cfg_wr_data,
  input  logic             ep_en_set,
  input  logic             iso_ep,
  input  logic             uframe_start,
  input  logic             fifo_wr_evt,
  input  logic [LEN_W-1:0] fifo_wr_len,
  input  logic             fifo_rd_evt,
  output logic [31:0]      cfg_rd_data,
  output logic             ep_enabled,
  output logic             xfer_done_irq,
  output logic             len_err,
  output logic [1:0]       data_pid
);
  localparam int PKT_LSB = XFER_W;
  localparam int MC_LSB  = XFER_W + PKT_W;
  localparam int USED    = MC_LSB + MC_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic              en_q, en_nxt;
  logic              irq_q, irq_nxt;
  logic              err_q, err_nxt;
  logic [MC_W-1:0]   mc_q;
  logic              cfg_load, wr_acc, rd_acc, done;
  logic [XFER_W-1:0] byte_cnt, byte_nxt;
  logic [PKT_W-1:0]  pkt_cnt, pkt_nxt;
  logic              overrun;
  data_pid_e         pid_sel;
  logic              unused_hi;

  assign cfg_load  = cfg_wr_en & ~en_q;
  assign wr_acc    = fifo_wr_evt & en_q;
  assign rd_acc    = fifo_rd_evt & en_q;
  assign unused_hi = ^cfg_wr_data[31:USED];

  usb_in_byte_ctr #(.W(XFER_W), .LEN_W(LEN_W)) u_bytes (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (cfg_load),
    .load_val  (cfg_wr_data[XFER_W-1:0]),
    .dec_en    (wr_acc),
    .dec_len   (fifo_wr_len),
    .count     (byte_cnt),
    .count_nxt (byte_nxt),
    .overrun   (overrun)
  );

  usb_in_pkt_ctr #(.W(PKT_W)) u_pkts (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (cfg_load),
    .load_val  (cfg_wr_data[PKT_LSB +: PKT_W]),
    .dec_en    (rd_acc),
    .count     (pkt_cnt),
    .count_nxt (pkt_nxt)
  );

  usb_in_iso_pid #(.MC_W(MC_W)) u_pid (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .iso          (iso_ep),
    .mc           (mc_q),
    .uframe_start (uframe_start),
    .pkt_sent     (rd_acc),
    .pid          (pid_sel)
  );

  // next-state logic
  always_comb begin
    done    = en_q && (byte_nxt == '0) && (pkt_nxt == '0);
    en_nxt  = en_q ? ~done : ep_en_set;
    irq_nxt = done;
    if (cfg_load) begin
      err_nxt = 1'b0;
    end else begin
      err_nxt = err_q | overrun;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      irq_q <= irq_nxt;
      err_q <= err_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mc_q <= '0;
    end else if (cfg_load) begin
      mc_q <= cfg_wr_data[MC_LSB +: MC_W];
    end
  end

  always_comb begin
    cfg_rd_data                      = '0;
    cfg_rd_data[XFER_W-1:0]          = byte_cnt;
    cfg_rd_data[PKT_LSB +: PKT_W]    = pkt_cnt;
    cfg_rd_data[MC_LSB +: MC_W]      = mc_q;
  end

  assign ep_enabled    = en_q;
  assign xfer_done_irq = irq_q;
  assign len_err       = err_q;
  assign data_pid      = pid_sel;
endmodule

// File: rtl/usb_in_xfer_ctr_chk.sv
module usb_in_xfer_ctr_chk #(
  parameter int XFER_W = 19,
  parameter int PKT_W  = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic        ep_en_set,
  input logic        fifo_wr_evt,
  input logic        fifo_rd_evt,
  input logic [31:0] cfg_rd_data,
  input logic        ep_enabled,
  input logic        xfer_done_irq,
  input logic        len_err,
  input logic [1:0]  data_pid
);
  localparam int PKT_LSB = XFER_W;

  logic [PKT_W-1:0] pkt_f;
  assign pkt_f = cfg_rd_data[PKT_LSB +: PKT_W];

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[31] == 1'b0);

  a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_enabled && cfg_wr_en && !fifo_wr_evt && !fifo_rd_evt) |=> $stable(cfg_rd_data));

  a_r5_pkt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_enabled && fifo_rd_evt && (pkt_f != '0)) |=> (pkt_f == $past(pkt_f) - PKT_W'(1)));

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_irq |=> !xfer_done_irq);

  a_r6_irq_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_irq |-> (!ep_enabled && (cfg_rd_data[PKT_LSB+PKT_W-1:0] == '0)));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err && !(cfg_wr_en && !ep_enabled)) |=> len_err);

  a_r8_pid_legal: assert property (@(posedge clk) disable iff (!rst_n)
    data_pid != 2'b11);

  a_r10_enable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_enabled && ep_en_set) |=> ep_enabled);
endmodule

bind usb_in_xfer_ctr usb_in_xfer_ctr_chk #(.XFER_W(XFER_W), .PKT_W(PKT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cfg_wr_en     (cfg_wr_en),
  .ep_en_set     (ep_en_set),
  .fifo_wr_evt   (fifo_wr_evt),
  .fifo_rd_evt   (fifo_rd_evt),
  .cfg_rd_data   (cfg_rd_data),
  .ep_enabled    (ep_enabled),
  .xfer_done_irq (xfer_done_irq),
  .len_err       (len_err),
  .data_pid      (data_pid)
);

// File: tb/usb_in_xfer_ctr_tb.sv
`timescale 1ns/1ps
module usb_in_xfer_ctr_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic        ep_en_set;
  logic        iso_ep;
  logic        uframe_start;
  logic        fifo_wr_evt;
  logic [10:0] fifo_wr_len;
  logic        fifo_rd_evt;
  logic [31:0] cfg_rd_data;
  logic        ep_enabled;
  logic        xfer_done_irq;
  logic        len_err;
  logic [1:0]  data_pid;

  int  n_checks;
  int  n_errors;
  bit  finished;

  localparam int NVEC = 4;
  localparam int V_BYTES [NVEC] = '{1024, 300, 64, 1000};
  localparam int V_PKTS  [NVEC] = '{2,    3,   1,  8};
  localparam int V_LEN   [NVEC] = '{512,  128, 64, 125};

  usb_in_xfer_ctr u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_data   (cfg_wr_data),
    .ep_en_set     (ep_en_set),
    .iso_ep        (iso_ep),
    .uframe_start  (uframe_start),
    .fifo_wr_evt   (fifo_wr_evt),
    .fifo_wr_len   (fifo_wr_len),
    .fifo_rd_evt   (fifo_rd_evt),
    .cfg_rd_data   (cfg_rd_data),
    .ep_enabled    (ep_enabled),
    .xfer_done_irq (xfer_done_irq),
    .len_err       (len_err),
    .data_pid      (data_pid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] pack(input int b, input int p, input int m);
    logic [31:0] w;
    w = '0;
    w[18:0]  = b[18:0];
    w[28:19] = p[9:0];
    w[30:29] = m[1:0];
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic prog(input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic enable();
    ep_en_set = 1'b1;
    tick();
    ep_en_set = 1'b0;
  endtask

  task automatic fwr(input int len);
    fifo_wr_evt = 1'b1; fifo_wr_len = len[10:0];
    tick();
    fifo_wr_evt = 1'b0;
  endtask

  task automatic frd();
    fifo_rd_evt = 1'b1;
    tick();
    fifo_rd_evt = 1'b0;
  endtask

  task automatic both(input int len);
    fifo_wr_evt = 1'b1; fifo_wr_len = len[10:0]; fifo_rd_evt = 1'b1;
    tick();
    fifo_wr_evt = 1'b0; fifo_rd_evt = 1'b0;
  endtask

  task automatic uframe();
    uframe_start = 1'b1;
    tick();
    uframe_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; finished = 1'b0;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; ep_en_set = 1'b0;
    iso_ep = 1'b0; uframe_start = 1'b0; fifo_wr_evt = 1'b0; fifo_wr_len = '0;
    fifo_rd_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 word", cfg_rd_data, 32'h0);
    chk("R1 enable", {31'h0, ep_enabled}, 32'h0);
    chk("R1 irq", {31'h0, xfer_done_irq}, 32'h0);
    chk("R1 err", {31'h0, len_err}, 32'h0);
    chk("R1 pid", {30'h0, data_pid}, 32'h0);

    // vector table: program, enable, drain packet by packet
    for (int i = 0; i < NVEC; i++) begin
      int rem;
      int pk;
      int l;
      rem = V_BYTES[i];
      pk  = V_PKTS[i];
      prog(pack(rem, pk, 0));
      chk("R2 readback", cfg_rd_data, pack(rem, pk, 0));
      enable();
      chk("R10 enable", {31'h0, ep_enabled}, 32'h1);
      while (rem > 0) begin
        l = (rem < V_LEN[i]) ? rem : V_LEN[i];
        fwr(l);
        rem -= l;
        chk("R4 bytes", {13'h0, cfg_rd_data[18:0]}, rem);
        frd();
        pk -= 1;
        if (rem == 0 && pk == 0) begin
          chk("R6 irq", {31'h0, xfer_done_irq}, 32'h1);
          chk("R6 disable", {31'h0, ep_enabled}, 32'h0);
        end else begin
          chk("R5 pkts", {22'h0, cfg_rd_data[28:19]}, pk);
        end
      end
      tick();
      chk("R6 pulse width", {31'h0, xfer_done_irq}, 32'h0);
    end

    // R2 layout with all ones; bit 31 reads zero
    prog(32'hFFFF_FFFF);
    chk("R2 reserved bit", cfg_rd_data, 32'h7FFF_FFFF);
    // R5 events while disabled ignored
    fwr(10);
    frd();
    chk("R5 disabled events", cfg_rd_data, 32'h7FFF_FFFF);

    // R3 write while enabled ignored
    prog(pack(200, 2, 1));
    enable();
    prog(pack(7, 7, 3));
    chk("R3 write ignored", cfg_rd_data, pack(200, 2, 1));

    // R9 simultaneous write and read events
    both(100);
    chk("R9 both applied", cfg_rd_data, pack(100, 1, 1));
    chk("R9 still enabled", {31'h0, ep_enabled}, 32'h1);
    both(100);
    chk("R9 final irq", {31'h0, xfer_done_irq}, 32'h1);
    chk("R9 final word", cfg_rd_data, pack(0, 0, 1));
    chk("R9 final disable", {31'h0, ep_enabled}, 32'h0);
    tick();

    // R6 packet count empty first does not complete
    prog(pack(50, 1, 0));
    enable();
    frd();
    chk("R6 no early done", {30'h0, ep_enabled, xfer_done_irq}, 32'h2);
    fwr(50);
    chk("R6 done after bytes", {30'h0, ep_enabled, xfer_done_irq}, 32'h1);
    tick();

    // R6 enable with zero counts completes next edge
    prog(32'h0);
    enable();
    chk("R6 zero enable", {31'h0, ep_enabled}, 32'h1);
    tick();
    chk("R6 zero done", {30'h0, ep_enabled, xfer_done_irq}, 32'h1);
    tick();

    // R7 overrun
    prog(pack(100, 2, 0));
    enable();
    fwr(150);
    chk("R7 saturate", {13'h0, cfg_rd_data[18:0]}, 32'h0);
    chk("R7 err set", {31'h0, len_err}, 32'h1);
    frd();
    chk("R7 err held", {31'h0, len_err}, 32'h1);
    frd();
    chk("R7 done with err", {30'h0, xfer_done_irq, len_err}, 32'h3);
    prog(32'h0);
    chk("R7 err cleared", {31'h0, len_err}, 32'h0);

    // R8 isochronous PID, mc = 3
    iso_ep = 1'b1;
    prog(pack(300, 3, 3));
    enable();
    uframe();
    chk("R8 mc3 first", {30'h0, data_pid}, 32'd2);
    frd();
    chk("R8 mc3 second", {30'h0, data_pid}, 32'd1);
    frd();
    chk("R8 mc3 third", {30'h0, data_pid}, 32'd0);
    frd();
    chk("R8 floor", {30'h0, data_pid}, 32'd0);
    uframe();
    chk("R8 new uframe", {30'h0, data_pid}, 32'd2);
    fwr(300);
    chk("R8 drained", {31'h0, xfer_done_irq}, 32'h1);
    tick();

    // R8 mc = 2 then non-iso
    prog(pack(10, 2, 2));
    enable();
    uframe();
    chk("R8 mc2 first", {30'h0, data_pid}, 32'd1);
    frd();
    chk("R8 mc2 second", {30'h0, data_pid}, 32'd0);
    uframe();
    iso_ep = 1'b0;
    #1;
    chk("R8 non-iso", {30'h0, data_pid}, 32'd0);
    tick();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule